// File: doc/BRIEF.md
# Retriggerable One-Shot and Gated Square-Wave Timer

A synchronous timing block that replaces a resistor-capacitor multivibrator with cycle counting. A mode-select input picks between two behaviours. In one-shot mode, a rising edge on one trigger input or a falling edge on the other starts a pulse of a fixed number of clock cycles. A retrigger edge that arrives while the pulse is high restarts the count, so the pulse is extended. In astable mode, a square wave with equal high and low halves runs for as long as the enable input stays high.

Both durations are elaboration-time cycle counts. `PULSE_LEN` sets the one-shot width and `HALF_LEN` sets each astable half-period. They are separate parameters because, for the same timing setting, an oscillator period is not simply twice a pulse width. A length of 0 is treated as 1. Every control input passes through a two-flop synchronizer. An active-high reset clears the outputs asynchronously, so a pulse or an oscillation ends at once.

Top module: `oneshot_astable_timer`

## Requirements
- R1: With `mode_sel`=0 (one-shot) and the block idle, a 0-to-1 change on `trig_rise` drives `q_out` high on the third rising clock edge after the change.
- R2: With `mode_sel`=0 and the block idle, a 1-to-0 change on `trig_fall` starts a pulse with the same three-edge latency. A 0-to-1 change on `trig_fall` starts nothing.
- R3: A one-shot pulse stays high for exactly `PULSE_LEN` clock cycles, and for one cycle when `PULSE_LEN` is 0.
- R4: Edges on `trig_rise` or `trig_fall` that arrive while a pulse is high neither change its length nor start a second pulse.
- R5: A 0-to-1 change on `retrig` that takes effect while the pulse is high reloads the count, so `q_out` falls `PULSE_LEN` cycles after the edge on which the restart is applied. A `retrig` edge while the block is idle has no effect.
- R6: While `rst` is high, `q_out` is 0 and `qn_out` is 1 without waiting for a clock edge. After `rst` falls, an interrupted pulse does not resume.
- R7: With `mode_sel`=1 (astable), `q_out` rises on the third clock edge after `ast_en` rises. It then alternates between `HALF_LEN` cycles high and `HALF_LEN` cycles low (1 each when `HALF_LEN` is 0).
- R8: In astable mode, `q_out` is 0 by the third clock edge after `ast_en` falls and stays 0 while `ast_en` is low. The next enable starts with a full high half-period.
- R9: `qn_out` is always the inverse of `q_out`.
- R10: A change of `mode_sel` takes effect on the third clock edge after the change. It clears the count and drives `q_out` low, and the new mode then starts from idle.
- R11: In astable mode, edges on `trig_rise`, `trig_fall` and `retrig` have no effect on `q_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high master reset, asynchronous assertion |
| mode_sel | input | 1 | 0 = one-shot, 1 = astable |
| trig_rise | input | 1 | Starts a pulse on its rising edge |
| trig_fall | input | 1 | Starts a pulse on its falling edge |
| retrig | input | 1 | Rising edge restarts a running pulse |
| ast_en | input | 1 | Level gate for the oscillator |
| q_out | output | 1 | True output |
| qn_out | output | 1 | Complement of `q_out` |

## Verification
The width and half-period properties assume that every control input stays at each level for at least two clock cycles, so that the synchronizers deliver every edge. The bench holds each trigger, retrigger, enable and mode change for two or more cycles. The properties also assume that `rst` stays high across at least one clock edge. The bench holds it for three edges, and the asynchronous clear is checked between edges at the ports. The mode-change property relies on `mode_sel` being quasi-static, and the bench changes it only after the outputs have settled in the current mode.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_ASTABLE = 1'b1
  } mode_e;

  // A requested length of zero cycles is served as one cycle.
  function automatic int unsigned eff_len(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/ost_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank. With IS_EDGE the output is a one-cycle
// strobe on the active edge of each bit (falling where FALL_MASK is set),
// otherwise it is the synchronized level, inverted where FALL_MASK is set.
module ost_sync #(
  parameter int          W         = 1,
  parameter bit          IS_EDGE   = 1'b0,
  parameter logic [W-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  generate
    if (IS_EDGE) begin : g_edge
      logic [W-1:0] s3;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) s3 <= '0;
        else     s3 <= s2;
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = FALL_MASK[i] ? (s3[i] & ~s2[i]) : (s2[i] & ~s3[i]);
      end
    end else begin : g_level
      assign dout = s2 ^ FALL_MASK;
    end
  endgenerate
endmodule

// File: rtl/ost_down_counter.sv
`timescale 1ns/1ps
// Loadable down-counter that holds at zero. Priority: clear, load, count.
module ost_down_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/oneshot_astable_timer.sv
`timescale 1ns/1ps
module oneshot_astable_timer
  import ost_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int unsigned PULSE_LEN = 10,
  parameter int unsigned HALF_LEN  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic trig_rise,
  input  logic trig_fall,
  input  logic retrig,
  input  logic ast_en,
  output logic q_out,
  output logic qn_out
);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(eff_len(PULSE_LEN) - 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(eff_len(HALF_LEN) - 1);

  // Edge strobes: [0] rising trigger, [1] falling trigger, [2] retrigger.
  logic [2:0] strb;
  // Levels: [0] astable enable, [1] mode select.
  logic [1:0] lvl;

  ost_sync #(.W(3), .IS_EDGE(1'b1), .FALL_MASK(3'b010)) u_edge (
    .clk(clk), .rst(rst), .din({retrig, trig_fall, trig_rise}), .dout(strb)
  );
  ost_sync #(.W(2), .IS_EDGE(1'b0), .FALL_MASK(2'b00)) u_level (
    .clk(clk), .rst(rst), .din({mode_sel, ast_en}), .dout(lvl)
  );

  mode_e mode_q;
  logic  q_r, run_r, cnt_zero;

  // Named internal events, also observed by the checker.
  logic os_mode, mode_chg, aen_lvl;
  logic start_os, restart_os, os_expire;
  logic ast_start, ast_flip, ast_stop;

  assign aen_lvl    = lvl[0];
  assign os_mode    = (mode_q == MODE_ONESHOT);
  assign mode_chg   = (mode_e'(lvl[1]) != mode_q);

  assign start_os   = os_mode & ~mode_chg & ~q_r & (strb[0] | strb[1]);
  assign restart_os = os_mode & ~mode_chg &  q_r & strb[2];
  assign os_expire  = os_mode & ~mode_chg &  q_r & ~restart_os & cnt_zero;

  assign ast_stop   = ~os_mode & ~mode_chg & ~aen_lvl;
  assign ast_start  = ~os_mode & ~mode_chg &  aen_lvl & ~run_r;
  assign ast_flip   = ~os_mode & ~mode_chg &  aen_lvl &  run_r & cnt_zero;

  ost_down_counter #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (mode_chg | ast_stop | os_expire),
    .load     (start_os | restart_os | ast_start | ast_flip),
    .load_val (os_mode ? PULSE_LD : HALF_LD),
    .dec      (1'b1),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mode_q <= MODE_ONESHOT;
      q_r    <= 1'b0;
      run_r  <= 1'b0;
    end else begin
      mode_q <= mode_e'(lvl[1]);
      if (mode_chg) begin
        q_r   <= 1'b0;
        run_r <= 1'b0;
      end else if (os_mode) begin
        if (start_os)       q_r <= 1'b1;
        else if (os_expire) q_r <= 1'b0;
      end else begin
        if (ast_stop) begin
          q_r   <= 1'b0;
          run_r <= 1'b0;
        end else if (ast_start) begin
          q_r   <= 1'b1;
          run_r <= 1'b1;
        end else if (ast_flip) begin
          q_r   <= ~q_r;
        end
      end
    end
  end

  assign q_out  = q_r;
  assign qn_out = ~q_r;
endmodule

// File: rtl/ost_chk.sv
`timescale 1ns/1ps
module ost_chk
  import ost_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 10,
  parameter int unsigned HALF_LEN  = 9
) (
  input logic clk,
  input logic rst,
  input logic q,
  input logic qn,
  input logic os_mode,
  input logic mode_chg,
  input logic start_os,
  input logic restart_os,
  input logic ast_start,
  input logic ast_flip,
  input logic ast_run,
  input logic aen_lvl
);
  localparam int unsigned P_EFF = eff_len(PULSE_LEN);
  localparam int unsigned H_EFF = eff_len(HALF_LEN);
  localparam int unsigned CAP   = P_EFF + H_EFF + 4;

  // Cycles since the last (re)load of a one-shot or astable segment.
  int unsigned os_seg, ast_seg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      os_seg  <= 0;
      ast_seg <= 0;
    end else begin
      if (start_os | restart_os) os_seg <= 0;
      else if (os_seg < CAP)     os_seg <= os_seg + 1;
      if (ast_start | ast_flip)  ast_seg <= 0;
      else if (ast_seg < CAP)    ast_seg <= ast_seg + 1;
    end
  end

  // R9
  compl_chk: assert property (@(posedge clk) disable iff (rst) qn == ~q);

  // R6
  rst_clr_chk: assert property (@(posedge clk) rst |-> (!q && qn));

  // R3
  os_width_max_chk: assert property (@(posedge clk) disable iff (rst)
    (os_mode && q) |-> (os_seg < P_EFF));

  // R3
  os_width_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(q) && $past(os_mode) && !$past(mode_chg)) |-> (os_seg == P_EFF));

  // R7
  ast_half_max_chk: assert property (@(posedge clk) disable iff (rst)
    ast_run |-> (ast_seg < H_EFF));

  // R7
  ast_half_full_chk: assert property (@(posedge clk) disable iff (rst)
    (ast_run && $past(ast_run) && (q != $past(q))) |-> ($past(ast_seg) == H_EFF - 1));

  // R8
  ast_start_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ast_run) |-> q);

  // R8
  ast_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!os_mode && !aen_lvl) |=> !q);

  // R10
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !q);
endmodule

bind oneshot_astable_timer ost_chk #(.PULSE_LEN(PULSE_LEN), .HALF_LEN(HALF_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .q          (q_out),
  .qn         (qn_out),
  .os_mode    (os_mode),
  .mode_chg   (mode_chg),
  .start_os   (start_os),
  .restart_os (restart_os),
  .ast_start  (ast_start),
  .ast_flip   (ast_flip),
  .ast_run    (run_r),
  .aen_lvl    (aen_lvl)
);

// File: tb/tb_oneshot_astable_timer.sv
`timescale 1ns/1ps
module tb_oneshot_astable_timer;
  localparam int PL = 10;
  localparam int HL = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0, trig_rise = 1'b0, trig_fall = 1'b0, retrig = 1'b0, ast_en = 1'b0;
  logic q, qn, qz, qnz;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  oneshot_astable_timer #(.CNT_W(16), .PULSE_LEN(PL), .HALF_LEN(HL)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .trig_rise(trig_rise),
    .trig_fall(trig_fall), .retrig(retrig), .ast_en(ast_en),
    .q_out(q), .qn_out(qn)
  );

  // Zero lengths: both durations must behave as one cycle.
  oneshot_astable_timer #(.CNT_W(4), .PULSE_LEN(0), .HALF_LEN(0)) dut_z (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .trig_rise(trig_rise),
    .trig_fall(trig_fall), .retrig(retrig), .ast_en(ast_en),
    .q_out(qz), .qn_out(qnz)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // Outputs must stay low for n samples; returns number of high samples seen.
  task automatic count_high(input int n, output int hi, output int hiz, output int bad_inv);
    hi = 0; hiz = 0; bad_inv = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q) hi++;
      if (qz) hiz++;
      if (qn == q) bad_inv++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(q == 1'b0 && qn == 1'b1, "R6 reset state", q, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // One pulse: latency and width of dut, plus first pulse of dut_z.
  task automatic os_shot(input bit use_fall, input int retrig_k, input int noise_k,
                         output int lat, output int wid, output int latz, output int widz);
    bit seen = 0, fin = 0, seenz = 0, finz = 0;
    lat = 0; wid = 0; latz = 0; widz = 0;
    if (use_fall) trig_fall = 1'b0;
    else          trig_rise = 1'b1;
    for (int i = 1; i <= 300 && !fin; i++) begin
      @(negedge clk);
      if (i == 2) trig_rise = 1'b0;
      if (!finz) begin
        if (qz) begin
          if (!seenz) begin seenz = 1; latz = i; end
          widz++;
        end else if (seenz) finz = 1;
      end
      if (q) begin
        if (!seen) begin seen = 1; lat = i; end
        wid++;
        if (wid == retrig_k)     retrig = 1'b1;
        if (wid == retrig_k + 2) retrig = 1'b0;
        if (wid == noise_k)     begin trig_rise = 1'b1; trig_fall = 1'b1; end
        if (wid == noise_k + 2) begin trig_rise = 1'b0; trig_fall = 1'b0; end
      end else if (seen) fin = 1;
    end
    trig_rise = 1'b0; trig_fall = 1'b0; retrig = 1'b0;
  endtask

  task automatic t_rise_shot();
    int lat, wid, latz, widz, hi, hiz, bi;
    os_shot(1'b0, -10, -10, lat, wid, latz, widz);
    check(lat == 3, "R1 rise trigger latency", lat, 3);
    check(wid == PL, "R3 pulse width", wid, PL);
    check(latz == 3, "R1 rise trigger latency (zero length)", latz, 3);
    check(widz == 1, "R3 zero length width is one", widz, 1);
    count_high(8, hi, hiz, bi);
    check(hi == 0, "R1 single pulse only", hi, 0);
    check(bi == 0, "R9 complement during one-shot", bi, 0);
  endtask

  task automatic t_fall_shot();
    int lat, wid, latz, widz, hi, hiz, bi;
    trig_fall = 1'b1;
    count_high(6, hi, hiz, bi);
    check(hi == 0, "R2 rising edge of falling trigger ignored", hi, 0);
    os_shot(1'b1, -10, -10, lat, wid, latz, widz);
    check(lat == 3, "R2 fall trigger latency", lat, 3);
    check(wid == PL, "R2 fall trigger width", wid, PL);
    count_high(8, hi, hiz, bi);
  endtask

  task automatic t_ignore_triggers();
    int lat, wid, latz, widz, hi, hiz, bi;
    os_shot(1'b0, -10, 2, lat, wid, latz, widz);
    check(wid == PL, "R4 triggers during pulse do not change width", wid, PL);
    count_high(8, hi, hiz, bi);
    check(hi == 0, "R4 no second pulse from ignored triggers", hi, 0);
  endtask

  task automatic t_retrigger();
    int lat, wid, latz, widz, hi, hiz, bi;
    os_shot(1'b0, 4, -10, lat, wid, latz, widz);
    check(wid == 4 + 2 + PL, "R5 retrigger extends pulse", wid, 4 + 2 + PL);
    count_high(8, hi, hiz, bi);
    retrig = 1'b1;
    count_high(3, hi, hiz, bi);
    retrig = 1'b0;
    count_high(10, hi, hiz, bi);
    check(hi == 0, "R5 retrigger while idle ignored", hi, 0);
  endtask

  task automatic t_async_reset();
    int hi, hiz, bi;
    trig_rise = 1'b1;
    repeat (5) @(negedge clk);
    check(q == 1'b1, "R6 pulse running before reset", q, 1);
    trig_rise = 1'b0;
    #1 rst = 1'b1;
    #0.5;
    check(q == 1'b0 && qn == 1'b1, "R6 asynchronous clear", q, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    count_high(15, hi, hiz, bi);
    check(hi == 0, "R6 pulse does not resume after reset", hi, 0);
  endtask

  // Collect lengths of the first four runs after the first high sample.
  task automatic t_astable();
    int lat = 0, latz = 0, hi, hiz, bi;
    int runs[4], runz[4];
    int nr = 0, nz = 0, len = 0, lenz = 0;
    logic cur, curz;
    mode_sel = 1'b1;
    count_high(6, hi, hiz, bi);
    check(hi == 0, "R10 mode change leaves output low", hi, 0);
    trig_rise = 1'b1;
    count_high(3, hi, hiz, bi);
    trig_rise = 1'b0; retrig = 1'b1;
    count_high(3, hi, hiz, bi);
    retrig = 1'b0;
    count_high(10, hi, hiz, bi);
    check(hi == 0 && hiz == 0, "R11 triggers ignored in astable mode", hi, 0);
    ast_en = 1'b1;
    for (int i = 1; i <= 10 && lat == 0; i++) begin
      @(negedge clk);
      if (q) lat = i;
      if (qz && latz == 0) latz = i;
    end
    check(lat == 3, "R7 enable to first high latency", lat, 3);
    check(latz == 3, "R7 enable latency (zero length)", latz, 3);
    cur = q; curz = qz; len = 1; lenz = 1;
    for (int i = 0; i < 4 * HL + 6; i++) begin
      @(negedge clk);
      if (q == cur) len++;
      else begin
        if (nr < 4) runs[nr] = len;
        nr++; cur = q; len = 1;
      end
      if (qz == curz) lenz++;
      else begin
        if (nz < 4) runz[nz] = lenz;
        nz++; curz = qz; lenz = 1;
      end
      if (qn == q) bi++;
    end
    check(nr >= 4, "R7 four complete half-periods", nr, 4);
    for (int k = 0; k < 4; k++) begin
      check(runs[k] == HL, "R7 half-period length", runs[k], HL);
      check(runz[k] == 1, "R7 zero half-period is one", runz[k], 1);
    end
    check(bi == 0, "R9 complement during oscillation", bi, 0);
  endtask

  task automatic t_gate();
    int hi, hiz, bi, lat = 0, run = 0;
    bit done = 0;
    ast_en = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    check(q == 1'b0, "R8 output low three edges after disable", q, 0);
    count_high(2 * HL + 4, hi, hiz, bi);
    check(hi == 0, "R8 stays low while disabled", hi, 0);
    ast_en = 1'b1;
    for (int i = 1; i <= 40 && !done; i++) begin
      @(negedge clk);
      if (q) begin
        if (lat == 0) lat = i;
        run++;
      end else if (lat != 0) done = 1;
    end
    check(lat == 3, "R8 restart latency", lat, 3);
    check(run == HL, "R8 restart with full high half", run, HL);
  endtask

  task automatic t_mode_back();
    int hi, hiz, bi, lat, wid, latz, widz;
    while (!q) @(negedge clk);
    @(negedge clk);
    mode_sel = 1'b0;
    repeat (2) @(negedge clk);
    check(q == 1'b1, "R10 mode change not yet applied", q, 1);
    @(negedge clk);
    check(q == 1'b0, "R10 mode change clears output", q, 0);
    count_high(12, hi, hiz, bi);
    check(hi == 0, "R10 one-shot idle after mode change", hi, 0);
    os_shot(1'b0, -10, -10, lat, wid, latz, widz);
    check(wid == PL, "R10 one-shot width after mode change", wid, PL);
    ast_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_rise_shot();
    t_fall_shot();
    t_ignore_triggers();
    t_retrigger();
    t_async_reset();
    t_astable();
    t_gate();
    t_mode_back();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule